// File: doc/BRIEF.md
# Piecewise 12-to-10-bit Sample Compander

This block turns a stream of 12-bit linear samples into 10-bit codes. In compressed mode it applies a four-segment piecewise-linear law. Small values keep their full resolution. Each higher segment halves the resolution again, so the top segment keeps 9 effective bits. In linear mode it simply drops the two least significant bits. Each sample arrives with a valid strobe and a mode bit. One clock later the block presents the code in a register, together with a matching valid strobe.

The mode bit is sampled together with the data. A change of mode therefore applies to the sample that carries it and never to a sample already in the output register. The law truncates inside each segment, so the code never decreases as the input grows.

Top module: `cmp12to10_top`

## Requirements
- R1: After reset, `code_o` is 0 and `code_vld_o` is 0.
- R2: With `cmp_en_i`=1, inputs 0..255 give a code equal to the input.
- R3: With `cmp_en_i`=1, inputs 256..511 give code 256 + (x-256)/2, truncated (range 256..383).
- R4: With `cmp_en_i`=1, inputs 512..2047 give code 384 + (x-512)/4, truncated (range 384..767).
- R5: With `cmp_en_i`=1, inputs 2048..4095 give code 768 + (x-2048)/8, truncated (range 768..1023).
- R6: With `cmp_en_i`=0 (linear, the default mode), the code is x[11:2].
- R7: `code_vld_o` equals `smp_vld_i` of the previous cycle, and `code_o` holds the code for the sample that was valid in that cycle.
- R8: When `smp_vld_i`=0, `code_o` keeps its value, whatever the data and mode inputs do.
- R9: The mode used for a sample is the `cmp_en_i` value in that sample's own valid cycle.
- R10: In compressed mode, the code for x+1 is never less than the code for x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Input sample valid |
| smp_i | input | 12 | Linear input sample |
| cmp_en_i | input | 1 | 1 = piecewise compression, 0 = linear truncation |
| code_vld_o | output | 1 | Output code valid |
| code_o | output | 10 | Registered output code |

## Verification
The bench drives every segment boundary: 255/256, 511/512, 2047/2048 and 0/4095. An off-by-one segment decode would show up there as a jump or a repeated code. A sweep over all 4096 inputs compares each code with a model and checks that the code never decreases. That catches a rounding law or a wrong offset that would make the code step backwards at a boundary. Back-to-back samples with alternating mode expose a mode bit that is registered late and then applies to the wrong sample. Gaps in the valid strobe with noisy data expose an output register that updates without a valid sample.

// File: rtl/cmp12to10_pkg.sv
package cmp12to10_pkg;
  parameter int unsigned IN_W  = 12;
  parameter int unsigned OUT_W = 10;
  parameter int unsigned NSEG  = 4;

  typedef struct packed {
    logic [IN_W-1:0]  base_in;
    logic [OUT_W-1:0] base_out;
    logic [1:0]       shift;
  } seg_t;

  // segment k starts at input 0,256,512,2048 with step 2^k (k<3), last step 8
  function automatic seg_t seg_of(input int unsigned k);
    seg_t s;
    case (k)
      0: begin s.base_in = 12'd0;    s.base_out = 10'd0;   s.shift = 2'd0; end
      1: begin s.base_in = 12'd256;  s.base_out = 10'd256; s.shift = 2'd1; end
      2: begin s.base_in = 12'd512;  s.base_out = 10'd384; s.shift = 2'd2; end
      default: begin s.base_in = 12'd2048; s.base_out = 10'd768; s.shift = 2'd3; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cmp12to10_seg_sel.sv
module cmp12to10_seg_sel
  import cmp12to10_pkg::*;
(
  input  logic [IN_W-1:0] smp_i,
  output logic [1:0]      seg_o
);
  logic [NSEG-1:0] above;

  for (genvar k = 0; k < NSEG; k++) begin : g_cmp
    localparam seg_t S = seg_of(k);
    assign above[k] = (smp_i >= S.base_in);
  end

  // thermometer to index
  always_comb begin
    seg_o = 2'd0;
    for (int k = 1; k < int'(NSEG); k++)
      if (above[k]) seg_o = 2'(k);
  end
endmodule

// File: rtl/cmp12to10_law.sv
module cmp12to10_law
  import cmp12to10_pkg::*;
(
  input  logic [IN_W-1:0]  smp_i,
  input  logic             cmp_en_i,
  output logic [OUT_W-1:0] code_o
);
  localparam int unsigned DROP = IN_W - OUT_W;

  logic [1:0]       seg;
  logic [IN_W-1:0]  delta;
  logic [IN_W-1:0]  step;
  seg_t             s;

  cmp12to10_seg_sel u_sel (.smp_i(smp_i), .seg_o(seg));

  always_comb begin
    s      = seg_of(int'(seg));
    delta  = smp_i - s.base_in;
    step   = delta >> s.shift;
    if (cmp_en_i) code_o = s.base_out + step[OUT_W-1:0];
    else          code_o = smp_i[IN_W-1:DROP];
  end
endmodule

// File: rtl/cmp12to10_top.sv
module cmp12to10_top
  import cmp12to10_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [IN_W-1:0]  smp_i,
  input  logic             cmp_en_i,
  output logic             code_vld_o,
  output logic [OUT_W-1:0] code_o
);
  logic [OUT_W-1:0] code_d;

  cmp12to10_law u_law (.smp_i(smp_i), .cmp_en_i(cmp_en_i), .code_o(code_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_vld_o <= 1'b0;
      code_o     <= '0;
    end else begin
      code_vld_o <= smp_vld_i;
      if (smp_vld_i) code_o <= code_d;
    end
  end
endmodule

// File: rtl/cmp12to10_chk.sv
module cmp12to10_chk
  import cmp12to10_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_vld_i,
  input logic [IN_W-1:0]  smp_i,
  input logic             cmp_en_i,
  input logic             code_vld_o,
  input logic [OUT_W-1:0] code_o
);
  // R7
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld_o == $past(smp_vld_i));
  // R8
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(code_o));
  // R6
  linear_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !cmp_en_i) |=> code_o == $past(smp_i[IN_W-1:IN_W-OUT_W]));
  // R2
  low_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && cmp_en_i && smp_i < 12'd256) |=> code_o == $past(smp_i[OUT_W-1:0]));
  // R5
  top_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && cmp_en_i && smp_i[IN_W-1]) |=> code_o[OUT_W-1:OUT_W-2] == 2'b11);
  // R1
  always @(posedge clk_i)
    if (!rst_ni) rst_state_chk: assert (code_o == '0 && !code_vld_o);
endmodule

bind cmp12to10_top cmp12to10_chk i_chk (.*);

// File: tb/test_cmp12to10_top.sv
module test_cmp12to10_top;
  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0, mode = 1'b0;
  logic [11:0] smp = '0;
  logic ovld;
  logic [9:0] code;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cmp12to10_top i_cmp12to10_top (.clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld),
    .smp_i(smp), .cmp_en_i(mode), .code_vld_o(ovld), .code_o(code));

  function automatic int model(input int x, input bit m);
    if (!m)          return x / 4;
    if (x < 256)     return x;
    if (x < 512)     return 256 + (x - 256) / 2;
    if (x < 2048)    return 384 + (x - 512) / 4;
    return 768 + (x - 2048) / 8;
  endfunction

  function automatic string req_of(input int x, input bit m);
    if (!m)      return "R6";
    if (x < 256) return "R2";
    if (x < 512) return "R3";
    if (x < 2048) return "R4";
    return "R5";
  endfunction

  task automatic check(input string r, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // drive one valid sample, sample result mid-cycle after the edge
  task automatic send(input int x, input bit m, output int got);
    @(negedge clk); vld = 1'b1; smp = 12'(x); mode = m;
    @(negedge clk); vld = 1'b0; got = int'(code);
  endtask

  task automatic t_reset;
    #1;
    check("R1", int'(code), 0);
    check("R1", int'(ovld), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_boundaries;
    int xs[10] = '{0, 255, 256, 257, 511, 512, 515, 2047, 2048, 4095};
    foreach (xs[i]) begin
      int g;
      send(xs[i], 1'b1, g);
      check(req_of(xs[i], 1'b1), g, model(xs[i], 1'b1));
    end
  endtask

  task automatic t_linear;
    int xs[4] = '{0, 3, 2048, 4095};
    foreach (xs[i]) begin
      int g;
      send(xs[i], 1'b0, g);
      check("R6", g, model(xs[i], 1'b0));
    end
  endtask

  task automatic t_sweep;
    int prev = 0;
    for (int x = 0; x < 4096; x++) begin
      int g;
      send(x, 1'b1, g);
      check(req_of(x, 1'b1), g, model(x, 1'b1));
      if (g < prev) check("R10", g, prev);
      prev = g;
    end
    check("R10", prev, 1023);
  endtask

  task automatic t_stream_mode;
    // back-to-back samples with alternating mode
    @(negedge clk);
    vld = 1'b1; smp = 12'd1000; mode = 1'b1;
    @(negedge clk);
    check("R7", int'(ovld), 1);
    check("R9", int'(code), model(1000, 1'b1));
    smp = 12'd1000; mode = 1'b0;
    @(negedge clk);
    check("R9", int'(code), model(1000, 1'b0));
    smp = 12'd300; mode = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check("R9", int'(code), model(300, 1'b1));
    @(negedge clk);
    check("R7", int'(ovld), 0);
  endtask

  task automatic t_idle_hold;
    int g;
    send(2100, 1'b1, g);
    vld = 1'b0; smp = 12'd5; mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", int'(code), model(2100, 1'b1));
    check("R8", int'(ovld), 0);
    mode = 1'b1; smp = 12'd4000;
    @(negedge clk);
    check("R8", int'(code), model(2100, 1'b1));
  endtask

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_boundaries();
    t_linear();
    t_stream_mode();
    t_idle_hold();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule